// File: doc/BRIEF.md
# Power Switch Fault Supervisor

This block watches the protection flags around one internal high-side switch and one external low-side switch and decides when each gate must be held off. It receives comparator flags that are already synchronized to its clock: high-side overcurrent, low-side gate high, low-side drain above its overload threshold, output overtemperature, driver or bootstrap overtemperature, and supply undervoltage. It also receives the high-side and low-side commands and an enable. From these it drives a gate inhibit for each switch, an active-low fault status, an active-low current-sense fault indicator, a temperature-fault indicator, and a disable for the current source that biases the overload-threshold pin.

Overcurrent and low-side overload are latched. Each one is released only when its own command input has been held low for a minimum number of clock cycles, or when supply undervoltage is reported. Both overtemperature kinds are self-recovering: they hold the affected gates off only while their flag is present. Enable low means sleep: both gates are inhibited and every latch and timer returns to its reset value. All timing is set in clock cycles. The defaults assume a 1 MHz clock: a 200-cycle release hold and a 3-cycle overload filter, which is 2.5 µs rounded up.

Top module: `psw_fault_sup`

## Requirements
- R1: While `enIn` is low, `hsInhibit` and `lsInhibit` are both 1 in the same cycle. On the first clock edge with `enIn` low, both latches and all timers are cleared, so a fault latched before sleep is gone after wake-up.
- R2: When `ocFlag` is sampled high on an edge with `enIn` high and `uvFlag` low, the overcurrent latch sets. `hsInhibit` is 1 from the cycle after that edge, which is well inside the 10-cycle limit. It stays 1 after `ocFlag` falls.
- R3: The overcurrent latch clears on the edge that completes `CLR_HOLD_CYC` consecutive samples of `hsCmd` low. A single high sample restarts the count from zero.
- R4: `csFaultN` is 0 exactly while the overcurrent latch is set and `hsCmd` is 1. When `hsCmd` goes low it returns to 1 in the same cycle.
- R5: The overload latch sets on the edge that completes `OVL_FILT_CYC` consecutive samples in which `lsCmd`, `lsGateHi` and `lsDrainHi` are all 1. A sample with any of the three low restarts the count. With `lsCmd` low nothing is armed.
- R6: While the overload latch is set, `lsInhibit` and `ocsDisable` are both 1. The latch clears on the edge that completes `CLR_HOLD_CYC` consecutive samples of `lsCmd` low.
- R7: `outOtFlag` makes `hsInhibit` 1 in the same cycle without affecting `lsInhibit`. It does not latch: `hsInhibit` falls in the cycle the flag falls, provided no other cause is active.
- R8: `drvOtFlag` makes both `hsInhibit` and `lsInhibit` 1 in the same cycle, and it does not latch.
- R9: `tempFault` is 1 in any cycle in which either overtemperature flag is 1.
- R10: `faultN` is 0 whenever either latch is set or either overtemperature flag is 1, and 1 otherwise.
- R11: `uvFlag` sampled high clears both latches on that edge. This takes priority over a set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing tick clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enIn | input | 1 | Enable; low selects sleep |
| hsCmd | input | 1 | High-side on command |
| lsCmd | input | 1 | Low-side on command |
| ocFlag | input | 1 | High-side overcurrent comparator |
| lsGateHi | input | 1 | Low-side gate above turn-on level |
| lsDrainHi | input | 1 | Low-side drain above overload threshold |
| outOtFlag | input | 1 | Output switch overtemperature |
| drvOtFlag | input | 1 | Bootstrap or low-side driver overtemperature |
| uvFlag | input | 1 | Supply undervoltage |
| hsInhibit | output | 1 | Force high-side gate off |
| lsInhibit | output | 1 | Force low-side gate off |
| faultN | output | 1 | Fault status, active low |
| csFaultN | output | 1 | Current-sense fault indication, active low |
| tempFault | output | 1 | Any overtemperature present |
| ocsDisable | output | 1 | Turn off the overload-threshold current source |

## Verification
Latch effects are due one edge after the deciding sample. That applies to overcurrent set, overload set after its last qualifying sample, release after the last low command sample, and undervoltage and sleep clears. The overtemperature, enable and sense-indicator paths respond in the same cycle as their inputs.

The bench drives inputs just after a rising edge and compares every output at the falling edge against a behavioural model. That model updates its state at the rising edge from the inputs held at that edge. Directed checks are placed by counting edges: for example, the latch is still set after `CLR_HOLD_CYC-1` low samples and released one edge later.

// File: rtl/psw_fault_pkg.sv
package psw_fault_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // sleep: drop every timer
    logic ovlArm;   // overload filter may count
  } dpCtlT;

  // status from datapath back to control
  typedef struct packed {
    logic hsHoldDone;   // high-side command low long enough
    logic lsHoldDone;   // low-side command low long enough
    logic ovlQualDone;  // overload condition held long enough
  } dpStatT;

endpackage

// File: rtl/psw_fault_dp.sv
module psw_fault_dp
  import psw_fault_pkg::*;
#(
  parameter int CLR_HOLD_CYC = 200,
  parameter int OVL_FILT_CYC = 3
)(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtlT  ctl,
  input  logic   hsCmd,
  input  logic   lsCmd,
  input  logic   lsGateHi,
  input  logic   lsDrainHi,
  output dpStatT stat
);

  localparam int NCH    = 2;
  localparam int HOLD_W = $clog2(CLR_HOLD_CYC + 1);
  localparam int FILT_W = $clog2(OVL_FILT_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(CLR_HOLD_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_SAT  = HOLD_W'(CLR_HOLD_CYC);
  localparam logic [FILT_W-1:0] FILT_LAST = FILT_W'(OVL_FILT_CYC - 1);

  logic [NCH-1:0] cmdVec;
  logic [NCH-1:0] holdDone;

  assign cmdVec = {lsCmd, hsCmd};

  // one low-hold timer per command channel
  for (genvar ch = 0; ch < NCH; ch++) begin : gHold
    logic [HOLD_W-1:0] lowRun;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowRun <= '0;
      end else if (ctl.clrAll || cmdVec[ch]) begin
        lowRun <= '0;
      end else if (lowRun != HOLD_SAT) begin
        lowRun <= lowRun + 1'b1;
      end
    end

    // current sample low and enough earlier low samples
    assign holdDone[ch] = !cmdVec[ch] && (lowRun >= HOLD_LAST);
  end

  // overload run-length filter
  logic              qualNow;
  logic [FILT_W-1:0] qualRun;

  assign qualNow = ctl.ovlArm && lsGateHi && lsDrainHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualRun <= '0;
    end else if (!qualNow) begin
      qualRun <= '0;
    end else if (qualRun != FILT_LAST) begin
      qualRun <= qualRun + 1'b1;
    end
  end

  always_comb begin
    stat.hsHoldDone  = holdDone[0];
    stat.lsHoldDone  = holdDone[1];
    stat.ovlQualDone = qualNow && (qualRun >= FILT_LAST);
  end

endmodule

// File: rtl/psw_fault_ctrl.sv
module psw_fault_ctrl
  import psw_fault_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enIn,
  input  logic   hsCmd,
  input  logic   lsCmd,
  input  logic   ocFlag,
  input  logic   outOtFlag,
  input  logic   drvOtFlag,
  input  logic   uvFlag,
  input  dpStatT stat,
  output dpCtlT  ctl,
  output logic   hsInhibit,
  output logic   lsInhibit,
  output logic   faultN,
  output logic   csFaultN,
  output logic   tempFault,
  output logic   ocsDisable
);

  logic ocLat;
  logic ovlLat;
  logic anyOt;

  // overcurrent latch: sleep/undervoltage clear, then set, then release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocLat <= 1'b0;
    end else if (!enIn || uvFlag) begin
      ocLat <= 1'b0;
    end else if (ocFlag) begin
      ocLat <= 1'b1;
    end else if (stat.hsHoldDone) begin
      ocLat <= 1'b0;
    end
  end

  // low-side overload latch, same priority order
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlLat <= 1'b0;
    end else if (!enIn || uvFlag) begin
      ovlLat <= 1'b0;
    end else if (stat.ovlQualDone) begin
      ovlLat <= 1'b1;
    end else if (stat.lsHoldDone) begin
      ovlLat <= 1'b0;
    end
  end

  always_comb begin
    ctl.clrAll = !enIn;
    ctl.ovlArm = enIn && lsCmd && !ovlLat;
  end

  assign anyOt      = outOtFlag || drvOtFlag;
  assign hsInhibit  = !enIn || ocLat || anyOt;
  assign lsInhibit  = !enIn || ovlLat || drvOtFlag;
  assign tempFault  = anyOt;
  assign faultN     = !(ocLat || ovlLat || anyOt);
  assign csFaultN   = !(ocLat && hsCmd);
  assign ocsDisable = ovlLat;

endmodule

// File: rtl/psw_fault_sup.sv
module psw_fault_sup
  import psw_fault_pkg::*;
#(
  parameter int CLR_HOLD_CYC = 200,
  parameter int OVL_FILT_CYC = 3
)(
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic hsCmd,
  input  logic lsCmd,
  input  logic ocFlag,
  input  logic lsGateHi,
  input  logic lsDrainHi,
  input  logic outOtFlag,
  input  logic drvOtFlag,
  input  logic uvFlag,
  output logic hsInhibit,
  output logic lsInhibit,
  output logic faultN,
  output logic csFaultN,
  output logic tempFault,
  output logic ocsDisable
);

  dpCtlT  ctl;
  dpStatT stat;

  psw_fault_dp #(
    .CLR_HOLD_CYC(CLR_HOLD_CYC),
    .OVL_FILT_CYC(OVL_FILT_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .hsCmd    (hsCmd),
    .lsCmd    (lsCmd),
    .lsGateHi (lsGateHi),
    .lsDrainHi(lsDrainHi),
    .stat     (stat)
  );

  psw_fault_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enIn      (enIn),
    .hsCmd     (hsCmd),
    .lsCmd     (lsCmd),
    .ocFlag    (ocFlag),
    .outOtFlag (outOtFlag),
    .drvOtFlag (drvOtFlag),
    .uvFlag    (uvFlag),
    .stat      (stat),
    .ctl       (ctl),
    .hsInhibit (hsInhibit),
    .lsInhibit (lsInhibit),
    .faultN    (faultN),
    .csFaultN  (csFaultN),
    .tempFault (tempFault),
    .ocsDisable(ocsDisable)
  );

endmodule

// File: rtl/psw_fault_chk.sv
module psw_fault_chk (
  input logic clk,
  input logic rstN,
  input logic enIn,
  input logic hsCmd,
  input logic lsCmd,
  input logic ocFlag,
  input logic lsGateHi,
  input logic lsDrainHi,
  input logic outOtFlag,
  input logic drvOtFlag,
  input logic uvFlag,
  input logic hsInhibit,
  input logic lsInhibit,
  input logic faultN,
  input logic csFaultN,
  input logic tempFault,
  input logic ocsDisable
);

  a_r1_sleep_inhibits: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |-> (hsInhibit && lsInhibit));

  a_r2_oc_blocks_next: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && ocFlag && !uvFlag) |=> hsInhibit);

  a_r4_sense_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !csFaultN |-> (hsCmd && hsInhibit && !faultN));

  a_r5_arm_needs_all: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocsDisable) |-> ($past(lsCmd) && $past(lsGateHi) && $past(lsDrainHi)));

  a_r6_source_off_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    ocsDisable |-> (lsInhibit && !faultN));

  a_r8_drv_ot_both: assert property (@(posedge clk) disable iff (!rstN)
    drvOtFlag |-> (hsInhibit && lsInhibit));

  a_r10_temp_reports: assert property (@(posedge clk) disable iff (!rstN)
    tempFault |-> !faultN);

  a_r11_uv_clears: assert property (@(posedge clk) disable iff (!rstN)
    (uvFlag && enIn) |=> !ocsDisable);

endmodule

bind psw_fault_sup psw_fault_chk u_chk (
  .clk(clk), .rstN(rstN), .enIn(enIn), .hsCmd(hsCmd), .lsCmd(lsCmd),
  .ocFlag(ocFlag), .lsGateHi(lsGateHi), .lsDrainHi(lsDrainHi),
  .outOtFlag(outOtFlag), .drvOtFlag(drvOtFlag), .uvFlag(uvFlag),
  .hsInhibit(hsInhibit), .lsInhibit(lsInhibit), .faultN(faultN),
  .csFaultN(csFaultN), .tempFault(tempFault), .ocsDisable(ocsDisable)
);

// File: tb/psw_fault_sup_bench.sv
`timescale 1ns/100ps
module psw_fault_sup_bench;

  localparam int HOLD = 200;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, hsCmd = 1'b0, lsCmd = 1'b0, ocFlag = 1'b0;
  logic lsGateHi = 1'b0, lsDrainHi = 1'b0, outOtFlag = 1'b0;
  logic drvOtFlag = 1'b0, uvFlag = 1'b0;
  logic hsInhibit, lsInhibit, faultN, csFaultN, tempFault, ocsDisable;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 1'b0;

  always #2.5 clk = ~clk;

  psw_fault_sup #(.CLR_HOLD_CYC(HOLD), .OVL_FILT_CYC(FILT)) u_psw_fault_sup (
    .clk(clk), .rstN(rstN), .enIn(enIn), .hsCmd(hsCmd), .lsCmd(lsCmd),
    .ocFlag(ocFlag), .lsGateHi(lsGateHi), .lsDrainHi(lsDrainHi),
    .outOtFlag(outOtFlag), .drvOtFlag(drvOtFlag), .uvFlag(uvFlag),
    .hsInhibit(hsInhibit), .lsInhibit(lsInhibit), .faultN(faultN),
    .csFaultN(csFaultN), .tempFault(tempFault), .ocsDisable(ocsDisable)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // behavioural reference: run lengths and two fault bits
  int  hsLowRun = 0, lsLowRun = 0, ovlRun = 0;
  bit  mOc = 0, mOvl = 0;

  always @(posedge clk) begin
    bit qual, hsRel, lsRel;
    if (!rstN || !enIn) begin
      hsLowRun = 0; lsLowRun = 0; ovlRun = 0; mOc = 0; mOvl = 0;
    end else begin
      qual  = lsCmd && !mOvl && lsGateHi && lsDrainHi;
      ovlRun = qual ? ovlRun + 1 : 0;
      hsLowRun = hsCmd ? 0 : hsLowRun + 1;
      lsLowRun = lsCmd ? 0 : lsLowRun + 1;
      hsRel = hsLowRun >= HOLD;
      lsRel = lsLowRun >= HOLD;
      if (hsLowRun > 100000) hsLowRun = 100000;
      if (lsLowRun > 100000) lsLowRun = 100000;
      if (uvFlag)            mOc = 0;
      else if (ocFlag)       mOc = 1;
      else if (hsRel)        mOc = 0;
      if (uvFlag)            mOvl = 0;
      else if (ovlRun >= FILT) mOvl = 1;
      else if (lsRel)        mOvl = 0;
    end
  end

  always @(negedge clk) begin
    if (!ended) begin
      check("R2 hsInhibit vs model", hsInhibit, !enIn || mOc || outOtFlag || drvOtFlag);
      check("R6 lsInhibit vs model", lsInhibit, !enIn || mOvl || drvOtFlag);
      check("R10 faultN vs model", faultN, !(mOc || mOvl || outOtFlag || drvOtFlag));
      check("R4 csFaultN vs model", csFaultN, !(mOc && hsCmd));
      check("R9 tempFault vs model", tempFault, outOtFlag || drvOtFlag);
      check("R6 ocsDisable vs model", ocsDisable, mOvl);
    end
  end

  task automatic edgeDrive(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    // reset state, sleeping
    @(negedge clk);
    check("R1 reset hsInhibit", hsInhibit, 1'b1);
    check("R1 reset lsInhibit", lsInhibit, 1'b1);
    check("R10 reset faultN", faultN, 1'b1);
    check("R6 reset ocsDisable", ocsDisable, 1'b0);
    edgeDrive(2); rstN = 1'b1;
    edgeDrive(1); enIn = 1'b1;
    @(negedge clk);
    check("R1 awake hsInhibit", hsInhibit, 1'b0);

    // overcurrent latch and sense indicator
    edgeDrive(1); hsCmd = 1'b1; ocFlag = 1'b1;
    edgeDrive(1); ocFlag = 1'b0;
    @(negedge clk);
    check("R2 latched hsInhibit", hsInhibit, 1'b1);
    check("R4 sense low while cmd high", csFaultN, 1'b0);
    edgeDrive(3);
    check("R2 stays after flag drops", hsInhibit, 1'b1);
    hsCmd = 1'b0;
    @(negedge clk);
    check("R4 sense released on cmd low", csFaultN, 1'b1);
    edgeDrive(100); hsCmd = 1'b1;
    edgeDrive(1); hsCmd = 1'b0;
    @(negedge clk);
    check("R3 restart keeps latch", hsInhibit, 1'b1);
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    check("R3 one sample short", hsInhibit, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R3 released after hold", hsInhibit, 1'b0);
    check("R10 released faultN", faultN, 1'b1);

    // overload: unarmed, broken run, full run
    edgeDrive(1); lsGateHi = 1'b1; lsDrainHi = 1'b1;
    edgeDrive(10);
    check("R5 unarmed with lsCmd low", ocsDisable, 1'b0);
    lsCmd = 1'b1;
    edgeDrive(FILT - 1); lsDrainHi = 1'b0;
    edgeDrive(1); lsDrainHi = 1'b1;
    @(negedge clk);
    check("R5 short run no latch", ocsDisable, 1'b0);
    repeat (FILT) @(posedge clk);
    @(negedge clk);
    check("R5 full run latches", ocsDisable, 1'b1);
    check("R6 gate held off", lsInhibit, 1'b1);
    check("R10 overload faultN", faultN, 1'b0);
    edgeDrive(1); lsCmd = 1'b0; lsGateHi = 1'b0; lsDrainHi = 1'b0;
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    check("R6 one sample short", ocsDisable, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R6 released", lsInhibit, 1'b0);

    // output overtemperature
    edgeDrive(1); hsCmd = 1'b1; outOtFlag = 1'b1;
    @(negedge clk);
    check("R7 hs off same cycle", hsInhibit, 1'b1);
    check("R7 ls untouched", lsInhibit, 1'b0);
    check("R9 temp flag", tempFault, 1'b1);
    edgeDrive(2); outOtFlag = 1'b0;
    @(negedge clk);
    check("R7 no latch", hsInhibit, 1'b0);
    // driver overtemperature
    edgeDrive(1); drvOtFlag = 1'b1;
    @(negedge clk);
    check("R8 ls off", lsInhibit, 1'b1);
    check("R8 hs off", hsInhibit, 1'b1);
    edgeDrive(2); drvOtFlag = 1'b0;
    @(negedge clk);
    check("R8 no latch", lsInhibit, 1'b0);

    // undervoltage clears both, and beats a set
    edgeDrive(1); ocFlag = 1'b1; lsCmd = 1'b1; lsGateHi = 1'b1; lsDrainHi = 1'b1;
    edgeDrive(1); ocFlag = 1'b0;
    edgeDrive(FILT); lsGateHi = 1'b0;
    @(negedge clk);
    check("R11 precondition overload", ocsDisable, 1'b1);
    uvFlag = 1'b1; ocFlag = 1'b1;
    edgeDrive(1); uvFlag = 1'b0; ocFlag = 1'b0;
    @(negedge clk);
    check("R11 oc cleared", hsInhibit, 1'b0);
    check("R11 overload cleared", ocsDisable, 1'b0);

    // sleep wipes a latched fault
    edgeDrive(1); ocFlag = 1'b1;
    edgeDrive(1); ocFlag = 1'b0; enIn = 1'b0;
    @(negedge clk);
    check("R1 sleep ls inhibit", lsInhibit, 1'b1);
    edgeDrive(1); enIn = 1'b1;
    @(negedge clk);
    check("R1 latch gone after wake", hsInhibit, 1'b0);
    check("R4 sense idle after wake", csFaultN, 1'b1);

    // mixed stimulus against the model
    for (int i = 0; i < 6000; i++) begin
      edgeDrive(1);
      if ($urandom_range(0, 299) == 0) hsCmd = ~hsCmd;
      if ($urandom_range(0, 249) == 0) lsCmd = ~lsCmd;
      ocFlag    = ($urandom_range(0, 399) == 0);
      lsGateHi  = ($urandom_range(0, 3) != 0);
      lsDrainHi = ($urandom_range(0, 3) != 0);
      outOtFlag = ($urandom_range(0, 99) == 0);
      drvOtFlag = ($urandom_range(0, 149) == 0);
      uvFlag    = ($urandom_range(0, 1999) == 0);
      enIn      = ($urandom_range(0, 2999) != 0);
    end
    edgeDrive(2);
    @(negedge clk);
    finishRun();
  end

endmodule